// File: doc/BRIEF.md
# Dispatch Group Former with Stall Classification

This block sits between the decoded micro-op queue and the schedulers of an out-of-order core. Each cycle it looks at the oldest instructions waiting at the head of the queue. It admits them strictly in program order into one dispatch group, and stops at the first instruction that cannot be admitted. The group is limited by a configurable width in micro-ops. Each admission is checked against credit counts for free reorder buffer entries, free physical rename registers, free entries in each scheduler, and free load queue and store queue entries. An instruction may also be marked as one that must dispatch alone.

When a cycle ends with a waiting instruction held back by a resource or grouping rule, the block names one cause for that cycle and increments a saturating counter for that cause. A cycle that ends only because the group is full is not counted as a stall. A second bank of saturating counters forms a histogram of how many micro-ops were dispatched in each cycle. The upstream queue pops `disp_cnt` entries. The counters are read as flat vectors and can be cleared with a synchronous input.

Top module: `dsc_dispatch_ctl`

## Requirements
- R1: Admission is in program order. `disp_take` is always a contiguous run of ones from slot 0, and every set bit lies within `q_valid`. Slot 0 is the oldest. The run ends at the first valid instruction that fails a check, or at the first invalid slot.
- R2: A group holds at most the effective width in micro-ops. The exception is an instruction that arrives at an empty group: it always passes the width check, even if it is larger than the width. A group that stops only because the next instruction would exceed the width is not a stall.
- R3: Each admitted instruction uses as many reorder buffer entries as its micro-op count. The micro-op total of the group never exceeds `rob_free`.
- R4: Each admitted instruction uses one entry of the scheduler selected by its `q_sched` index. For each scheduler, the number admitted in a cycle never exceeds that scheduler's field in `sched_free` (field s at bits s*CRD_W upward).
- R5: The destination-register total of the group never exceeds `prf_free` when `cfg_prf_size` is nonzero. When `cfg_prf_size` is zero, the register check always passes.
- R6: Each admitted load uses one entry of `lq_free`, and each admitted store uses one entry of `sq_free`.
- R7: An instruction with `q_solo` set is admitted only as the first member of a group. Once it is admitted, no further instruction joins that group.
- R8: The effective width equals `cfg_width`, with two exceptions: a value of 0 selects `DEF_W`, and values above `MAX_W` are clamped to `MAX_W`.
- R9: In a stall cycle, `stall_cause` is one-hot and names the first failing check of the blocked instruction. Checks are tried in this order: register (bit 0), reorder buffer (bit 1), scheduler (bit 2), load queue (bit 3), store queue (bit 4), solo rule (bit 5). Only the matching counter, at `stall_cnt[c*CNT_W +: CNT_W]`, increments at the next edge.
- R10: Every cycle, exactly one histogram bin increments: bin k for k dispatched micro-ops. Totals at or above `MAX_W` go to bin `MAX_W`. Bin b is `hist_cnt[b*CNT_W +: CNT_W]`.
- R11: Every counter holds at its all-ones value instead of wrapping. When `clr_cnt` is high at an edge, all counters go to zero, and this takes priority over any increment in that cycle.
- R12: After synchronous active-low reset, all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_cnt | input | 1 | Synchronous clear of all counters |
| cfg_width | input | CFGW_W | Requested group width in micro-ops, 0 selects the default |
| cfg_prf_size | input | CRD_W | Rename register pool size, 0 means unlimited |
| q_valid | input | SLOTS | Valid flags of the head-of-queue slots, slot 0 oldest |
| q_uops | input | SLOTS*UOP_W | Micro-op count per slot |
| q_regs | input | SLOTS*REG_W | Destination register count per slot |
| q_sched | input | SLOTS*SCH_W | Target scheduler index per slot |
| q_load | input | SLOTS | Slot is a load |
| q_store | input | SLOTS | Slot is a store |
| q_solo | input | SLOTS | Slot must dispatch alone |
| rob_free | input | CRD_W | Free reorder buffer entries |
| prf_free | input | CRD_W | Free physical registers |
| sched_free | input | N_SCHED*CRD_W | Free entries per scheduler |
| lq_free | input | CRD_W | Free load queue entries |
| sq_free | input | CRD_W | Free store queue entries |
| disp_take | output | SLOTS | Slots admitted this cycle |
| disp_cnt | output | INS_W | Number of instructions admitted |
| disp_uops | output | UOPS_W | Number of micro-ops admitted |
| stall_cause | output | N_CAUSE | One-hot stall cause of this cycle |
| stall_cnt | output | N_CAUSE*CNT_W | Per-cause stall counters |
| hist_cnt | output | N_BIN*CNT_W | Micro-ops-per-cycle histogram counters |

## Verification
The hardest situation to reach from the ports is an instruction that fails several checks at once, deep inside a partly built group. Proving the priority order depends on this case. So does the rule that running out of width is not a stall. To reach it, the random stimulus keeps every credit close to zero and makes scheduler collisions, loads, stores and solo markers common. As a result, in most cycles several checks fail together after one or two slots have already been admitted. Directed cycles cover the default and clamped width, an oversized instruction arriving at an empty group, and the unlimited register pool. Long runs with an empty queue, using a narrow counter width, drive the counters into saturation and then clear them.

// File: rtl/dsc_pkg.sv
// Shared definitions for the dispatch group former.
// Assumes: stall causes are numbered in their priority order.
package dsc_pkg;
    localparam int N_CAUSE = 6;

    typedef enum logic [2:0] {
        CAUSE_REG   = 3'd0,
        CAUSE_ROB   = 3'd1,
        CAUSE_SCHED = 3'd2,
        CAUSE_LQ    = 3'd3,
        CAUSE_SQ    = 3'd4,
        CAUSE_GROUP = 3'd5
    } stall_cause_e;
endpackage

// File: rtl/dsc_width_sel.sv
// Resolves the configured group width into the width actually used.
// Assumes: a zero request means default, oversize requests are clamped.
module dsc_width_sel #(
    parameter int MAX_W  = 4,
    parameter int DEF_W  = 2,
    parameter int CFGW_W = 4,
    parameter int EW_W   = 3
) (
    input  logic [CFGW_W-1:0] cfg_width,
    output logic [EW_W-1:0]   eff_w
);
    // Pick default, clamp, or pass through.
    always_comb begin
        if (cfg_width == '0) begin
            eff_w = EW_W'(DEF_W);
        end else if (int'(cfg_width) > MAX_W) begin
            eff_w = EW_W'(MAX_W);
        end else begin
            eff_w = EW_W'(cfg_width);
        end
    end
endmodule

// File: rtl/dsc_group_former.sv
// Forms one dispatch group from the head-of-queue slots in program order.
// Each slot is checked against the running totals of the slots already
// admitted. The first slot that fails ends the group. If that slot passed
// the width check, the first failing resource check is reported as the
// single stall cause.
// Assumes: q_valid is contiguous from slot 0; uop counts are at least 1.
module dsc_group_former
    import dsc_pkg::*;
#(
    parameter int SLOTS   = 4,
    parameter int UOP_W   = 2,
    parameter int REG_W   = 2,
    parameter int N_SCHED = 4,
    parameter int SCH_W   = 2,
    parameter int CRD_W   = 6,
    parameter int EW_W    = 3,
    parameter int INS_W   = 3,
    parameter int UOPS_W  = 4,
    parameter int SUM_W   = 7
) (
    input  logic [EW_W-1:0]          eff_w,
    input  logic                     prf_unlim,
    input  logic [SLOTS-1:0]         q_valid,
    input  logic [SLOTS*UOP_W-1:0]   q_uops,
    input  logic [SLOTS*REG_W-1:0]   q_regs,
    input  logic [SLOTS*SCH_W-1:0]   q_sched,
    input  logic [SLOTS-1:0]         q_load,
    input  logic [SLOTS-1:0]         q_store,
    input  logic [SLOTS-1:0]         q_solo,
    input  logic [CRD_W-1:0]         rob_free,
    input  logic [CRD_W-1:0]         prf_free,
    input  logic [N_SCHED*CRD_W-1:0] sched_free,
    input  logic [CRD_W-1:0]         lq_free,
    input  logic [CRD_W-1:0]         sq_free,
    output logic [SLOTS-1:0]         take,
    output logic [INS_W-1:0]         n_take,
    output logic [UOPS_W-1:0]        n_uops,
    output logic [N_CAUSE-1:0]       cause
);
    logic [SUM_W-1:0] acc_ins, acc_uop, acc_reg, acc_ld, acc_st;
    logic [SUM_W-1:0] sch_used [N_SCHED];
    logic [SUM_W-1:0] cur_u, cur_r, cur_free_sch;
    logic [SCH_W-1:0] cur_s;
    logic             halted, solo_in;
    logic             ok_w, ok_reg, ok_rob, ok_sch, ok_lq, ok_sq, ok_grp;

    // Walk the slots oldest first, accumulating admitted resources.
    always_comb begin
        take    = '0;
        cause   = '0;
        halted  = 1'b0;
        solo_in = 1'b0;
        acc_ins = '0;
        acc_uop = '0;
        acc_reg = '0;
        acc_ld  = '0;
        acc_st  = '0;
        cur_u = '0; cur_r = '0; cur_s = '0; cur_free_sch = '0;
        ok_w = 1'b0; ok_reg = 1'b0; ok_rob = 1'b0; ok_sch = 1'b0;
        ok_lq = 1'b0; ok_sq = 1'b0; ok_grp = 1'b0;
        for (int s = 0; s < N_SCHED; s++) begin
            sch_used[s] = '0;
        end
        for (int i = 0; i < SLOTS; i++) begin
            cur_u        = SUM_W'(q_uops[i*UOP_W +: UOP_W]);
            cur_r        = SUM_W'(q_regs[i*REG_W +: REG_W]);
            cur_s        = q_sched[i*SCH_W +: SCH_W];
            cur_free_sch = SUM_W'(sched_free[int'(cur_s)*CRD_W +: CRD_W]);
            ok_w   = (acc_ins == '0) || (acc_uop + cur_u <= SUM_W'(eff_w));
            ok_reg = prf_unlim || (acc_reg + cur_r <= SUM_W'(prf_free));
            ok_rob = (acc_uop + cur_u <= SUM_W'(rob_free));
            ok_sch = (sch_used[cur_s] + SUM_W'(1) <= cur_free_sch);
            ok_lq  = !q_load[i]  || (acc_ld + SUM_W'(1) <= SUM_W'(lq_free));
            ok_sq  = !q_store[i] || (acc_st + SUM_W'(1) <= SUM_W'(sq_free));
            ok_grp = !solo_in && !(q_solo[i] && acc_ins != '0);
            if (!halted && q_valid[i]) begin
                if (ok_w && ok_reg && ok_rob && ok_sch && ok_lq && ok_sq && ok_grp) begin
                    take[i]         = 1'b1;
                    acc_ins         = acc_ins + SUM_W'(1);
                    acc_uop         = acc_uop + cur_u;
                    acc_reg         = acc_reg + cur_r;
                    acc_ld          = acc_ld + SUM_W'(q_load[i]);
                    acc_st          = acc_st + SUM_W'(q_store[i]);
                    sch_used[cur_s] = sch_used[cur_s] + SUM_W'(1);
                    solo_in         = solo_in | q_solo[i];
                end else begin
                    halted = 1'b1;
                    if (ok_w) begin
                        if      (!ok_reg) cause[CAUSE_REG]   = 1'b1;
                        else if (!ok_rob) cause[CAUSE_ROB]   = 1'b1;
                        else if (!ok_sch) cause[CAUSE_SCHED] = 1'b1;
                        else if (!ok_lq)  cause[CAUSE_LQ]    = 1'b1;
                        else if (!ok_sq)  cause[CAUSE_SQ]    = 1'b1;
                        else              cause[CAUSE_GROUP] = 1'b1;
                    end
                end
            end else begin
                halted = 1'b1;
            end
        end
    end

    // Present the group totals.
    assign n_take = INS_W'(acc_ins);
    assign n_uops = UOPS_W'(acc_uop);
endmodule

// File: rtl/dsc_sat_counter.sv
// Event counter that sticks at all ones.
// Assumes: clear outranks increment; reset is synchronous active-low.
module dsc_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    // Count up to the top value and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (inc && (q != {W{1'b1}})) begin
            q <= q + W'(1);
        end
    end
endmodule

// File: rtl/dsc_dispatch_ctl.sv
// Dispatch group former with per-cause stall counters and a histogram of
// micro-ops dispatched per cycle.
// Assumes: the queue pops disp_cnt entries each cycle; credits are the
// free counts valid in the current cycle.
module dsc_dispatch_ctl
    import dsc_pkg::*;
#(
    parameter int MAX_W   = 4,
    parameter int DEF_W   = 2,
    parameter int UOP_W   = 2,
    parameter int REG_W   = 2,
    parameter int N_SCHED = 4,
    parameter int CRD_W   = 6,
    parameter int CNT_W   = 16,
    localparam int SLOTS  = MAX_W,
    localparam int CFGW_W = $clog2(MAX_W + 1) + 1,
    localparam int EW_W   = $clog2(MAX_W + 1),
    localparam int SCH_W  = (N_SCHED > 1) ? $clog2(N_SCHED) : 1,
    localparam int INS_W  = $clog2(SLOTS + 1),
    localparam int UOPS_W = $clog2(SLOTS * ((1 << UOP_W) - 1) + 1),
    localparam int SUM_W  = ((CRD_W > UOPS_W) ? CRD_W : UOPS_W) + 1,
    localparam int N_BIN  = MAX_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_cnt,
    input  logic [CFGW_W-1:0]        cfg_width,
    input  logic [CRD_W-1:0]         cfg_prf_size,
    input  logic [SLOTS-1:0]         q_valid,
    input  logic [SLOTS*UOP_W-1:0]   q_uops,
    input  logic [SLOTS*REG_W-1:0]   q_regs,
    input  logic [SLOTS*SCH_W-1:0]   q_sched,
    input  logic [SLOTS-1:0]         q_load,
    input  logic [SLOTS-1:0]         q_store,
    input  logic [SLOTS-1:0]         q_solo,
    input  logic [CRD_W-1:0]         rob_free,
    input  logic [CRD_W-1:0]         prf_free,
    input  logic [N_SCHED*CRD_W-1:0] sched_free,
    input  logic [CRD_W-1:0]         lq_free,
    input  logic [CRD_W-1:0]         sq_free,
    output logic [SLOTS-1:0]         disp_take,
    output logic [INS_W-1:0]         disp_cnt,
    output logic [UOPS_W-1:0]        disp_uops,
    output logic [N_CAUSE-1:0]       stall_cause,
    output logic [N_CAUSE*CNT_W-1:0] stall_cnt,
    output logic [N_BIN*CNT_W-1:0]   hist_cnt
);
    logic [EW_W-1:0]  eff_w;
    logic             prf_unlim;
    logic [N_BIN-1:0] bin_hit;

    // A zero pool size turns the register check off.
    assign prf_unlim = (cfg_prf_size == '0);

    dsc_width_sel #(
        .MAX_W (MAX_W),
        .DEF_W (DEF_W),
        .CFGW_W(CFGW_W),
        .EW_W  (EW_W)
    ) u_width (
        .cfg_width(cfg_width),
        .eff_w    (eff_w)
    );

    dsc_group_former #(
        .SLOTS  (SLOTS),
        .UOP_W  (UOP_W),
        .REG_W  (REG_W),
        .N_SCHED(N_SCHED),
        .SCH_W  (SCH_W),
        .CRD_W  (CRD_W),
        .EW_W   (EW_W),
        .INS_W  (INS_W),
        .UOPS_W (UOPS_W),
        .SUM_W  (SUM_W)
    ) u_group (
        .eff_w     (eff_w),
        .prf_unlim (prf_unlim),
        .q_valid   (q_valid),
        .q_uops    (q_uops),
        .q_regs    (q_regs),
        .q_sched   (q_sched),
        .q_load    (q_load),
        .q_store   (q_store),
        .q_solo    (q_solo),
        .rob_free  (rob_free),
        .prf_free  (prf_free),
        .sched_free(sched_free),
        .lq_free   (lq_free),
        .sq_free   (sq_free),
        .take      (disp_take),
        .n_take    (disp_cnt),
        .n_uops    (disp_uops),
        .cause     (stall_cause)
    );

    // One saturating counter per stall cause.
    for (genvar c = 0; c < N_CAUSE; c++) begin : g_stall
        dsc_sat_counter #(.W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr_cnt),
            .inc  (stall_cause[c]),
            .q    (stall_cnt[c*CNT_W +: CNT_W])
        );
    end

    // One histogram bin per micro-op total; the top bin takes the overflow.
    for (genvar b = 0; b < N_BIN; b++) begin : g_hist
        if (b == MAX_W) begin : g_top
            assign bin_hit[b] = (int'(disp_uops) >= b);
        end else begin : g_mid
            assign bin_hit[b] = (int'(disp_uops) == b);
        end
        dsc_sat_counter #(.W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr_cnt),
            .inc  (bin_hit[b]),
            .q    (hist_cnt[b*CNT_W +: CNT_W])
        );
    end
endmodule

// File: rtl/dsc_dispatch_ctl_chk.sv
// Property checker for the dispatch group former, bound to the top.
// Assumes: signals are sampled at the rising clock edge.
module dsc_dispatch_ctl_chk #(
    parameter int SLOTS   = 4,
    parameter int N_CAUSE = 6,
    parameter int N_BIN   = 5,
    parameter int CNT_W   = 16,
    parameter int INS_W   = 3,
    parameter int UOPS_W  = 4,
    parameter int CRD_W   = 6,
    parameter int EW_W    = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     clr_cnt,
    input logic [SLOTS-1:0]         q_valid,
    input logic [SLOTS-1:0]         disp_take,
    input logic [INS_W-1:0]         disp_cnt,
    input logic [UOPS_W-1:0]        disp_uops,
    input logic [CRD_W-1:0]         rob_free,
    input logic [CRD_W-1:0]         cfg_prf_size,
    input logic [EW_W-1:0]          eff_w,
    input logic [N_CAUSE-1:0]       stall_cause,
    input logic [N_CAUSE*CNT_W-1:0] stall_cnt,
    input logic [N_BIN*CNT_W-1:0]   hist_cnt
);
    p_take_prefix_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((SLOTS'(disp_take + SLOTS'(1)) & disp_take) == '0) && ((disp_take & ~q_valid) == '0));

    p_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_cnt > INS_W'(1)) |-> (int'(disp_uops) <= int'(eff_w)));

    p_rob_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(disp_uops) <= int'(rob_free));

    p_unlimited_regs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_prf_size == '0) |-> !stall_cause[0]);

    p_one_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stall_cause));

    p_stall_leaves_work_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_cause != '0) |-> (disp_take != q_valid));

    p_bin0_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_cnt && disp_uops == '0 && hist_cnt[CNT_W-1:0] != {CNT_W{1'b1}})
        |=> (hist_cnt[CNT_W-1:0] == $past(hist_cnt[CNT_W-1:0]) + CNT_W'(1)));

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt |=> (stall_cnt == '0 && hist_cnt == '0));

    p_saturate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_cnt[CNT_W-1:0] == {CNT_W{1'b1}} && !clr_cnt)
        |=> (hist_cnt[CNT_W-1:0] == {CNT_W{1'b1}}));
endmodule

bind dsc_dispatch_ctl dsc_dispatch_ctl_chk #(
    .SLOTS  (SLOTS),
    .N_CAUSE(dsc_pkg::N_CAUSE),
    .N_BIN  (N_BIN),
    .CNT_W  (CNT_W),
    .INS_W  (INS_W),
    .UOPS_W (UOPS_W),
    .CRD_W  (CRD_W),
    .EW_W   (EW_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_cnt     (clr_cnt),
    .q_valid     (q_valid),
    .disp_take   (disp_take),
    .disp_cnt    (disp_cnt),
    .disp_uops   (disp_uops),
    .rob_free    (rob_free),
    .cfg_prf_size(cfg_prf_size),
    .eff_w       (eff_w),
    .stall_cause (stall_cause),
    .stall_cnt   (stall_cnt),
    .hist_cnt    (hist_cnt)
);

// File: tb/dsc_dispatch_ctl_bench.sv
// Self-checking bench: directed corner cases followed by constrained random
// cycles, compared against a reference model written from the requirements.
module dsc_dispatch_ctl_bench;
    localparam int MW  = 4;
    localparam int DW  = 2;
    localparam int CW  = 8;
    localparam int CMX = (1 << CW) - 1;
    localparam int NC  = 6;
    localparam int NB  = MW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_cnt = 1'b0;
    logic [3:0]     cfg_width;
    logic [5:0]     cfg_prf_size;
    logic [3:0]     q_valid, q_load, q_store, q_solo;
    logic [7:0]     q_uops, q_regs, q_sched;
    logic [5:0]     rob_free, prf_free, lq_free, sq_free;
    logic [23:0]    sched_free;
    logic [3:0]     disp_take;
    logic [2:0]     disp_cnt;
    logic [3:0]     disp_uops;
    logic [5:0]     stall_cause;
    logic [NC*CW-1:0] stall_cnt;
    logic [NB*CW-1:0] hist_cnt;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int v_n, rob, prf, psize, lq, sq, cw;
    int v_u[4], v_r[4], v_s[4], sch[4];
    bit v_ld[4], v_st[4], v_solo[4];
    int m_stall[NC];
    int m_hist[NB];

    always #4 clk = ~clk;

    dsc_dispatch_ctl #(.MAX_W(MW), .DEF_W(DW), .CNT_W(CW)) u_dsc_dispatch_ctl (
        .clk(clk), .rst_n(rst_n), .clr_cnt(clr_cnt),
        .cfg_width(cfg_width), .cfg_prf_size(cfg_prf_size),
        .q_valid(q_valid), .q_uops(q_uops), .q_regs(q_regs), .q_sched(q_sched),
        .q_load(q_load), .q_store(q_store), .q_solo(q_solo),
        .rob_free(rob_free), .prf_free(prf_free), .sched_free(sched_free),
        .lq_free(lq_free), .sq_free(sq_free),
        .disp_take(disp_take), .disp_cnt(disp_cnt), .disp_uops(disp_uops),
        .stall_cause(stall_cause), .stall_cnt(stall_cnt), .hist_cnt(hist_cnt)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int eff_width(input int c);
        if (c == 0) return DW;
        if (c > MW) return MW;
        return c;
    endfunction

    // Reference group formation per R1-R9.
    function automatic void ref_group(output int ni, output int nu, output int cs);
        int ew, nr, nld, nst;
        int su[4];
        bit stop, solo_in, wok, rok, bok, sok, lok, qok, gok;
        ew = eff_width(cw);
        ni = 0; nu = 0; nr = 0; nld = 0; nst = 0; cs = -1;
        stop = 1'b0; solo_in = 1'b0;
        for (int k = 0; k < 4; k++) su[k] = 0;
        for (int i = 0; i < 4; i++) begin
            if (!stop) begin
                if (i >= v_n) begin
                    stop = 1'b1;
                end else begin
                    wok = (ni == 0) || (nu + v_u[i] <= ew);
                    rok = (psize == 0) || (nr + v_r[i] <= prf);
                    bok = (nu + v_u[i] <= rob);
                    sok = (su[v_s[i]] + 1 <= sch[v_s[i]]);
                    lok = !v_ld[i] || (nld + 1 <= lq);
                    qok = !v_st[i] || (nst + 1 <= sq);
                    gok = !solo_in && !(v_solo[i] && ni != 0);
                    if (wok && rok && bok && sok && lok && qok && gok) begin
                        ni++; nu += v_u[i]; nr += v_r[i];
                        nld += int'(v_ld[i]); nst += int'(v_st[i]);
                        su[v_s[i]]++;
                        solo_in = solo_in | v_solo[i];
                    end else begin
                        stop = 1'b1;
                        if (wok) begin
                            if (!rok)      cs = 0;
                            else if (!bok) cs = 1;
                            else if (!sok) cs = 2;
                            else if (!lok) cs = 3;
                            else if (!qok) cs = 4;
                            else           cs = 5;
                        end
                    end
                end
            end
        end
    endfunction

    task automatic drive();
        for (int i = 0; i < 4; i++) begin
            q_valid[i]          = (i < v_n);
            q_uops[i*2 +: 2]    = 2'(v_u[i]);
            q_regs[i*2 +: 2]    = 2'(v_r[i]);
            q_sched[i*2 +: 2]   = 2'(v_s[i]);
            q_load[i]           = v_ld[i];
            q_store[i]          = v_st[i];
            q_solo[i]           = v_solo[i];
            sched_free[i*6 +: 6] = 6'(sch[i]);
        end
        rob_free = 6'(rob); prf_free = 6'(prf); cfg_prf_size = 6'(psize);
        lq_free = 6'(lq); sq_free = 6'(sq); cfg_width = 4'(cw);
    endtask

    task automatic set_easy();
        v_n = 0; rob = 63; prf = 63; psize = 0; lq = 7; sq = 7; cw = 4;
        for (int i = 0; i < 4; i++) begin
            v_u[i] = 1; v_r[i] = 0; v_s[i] = i; sch[i] = 7;
            v_ld[i] = 1'b0; v_st[i] = 1'b0; v_solo[i] = 1'b0;
        end
    endtask

    task automatic cmp_counters();
        for (int c = 0; c < NC; c++)
            chk(int'(stall_cnt[c*CW +: CW]) == m_stall[c], "R9", "stall counter",
                int'(stall_cnt[c*CW +: CW]), m_stall[c]);
        for (int b = 0; b < NB; b++)
            chk(int'(hist_cnt[b*CW +: CW]) == m_hist[b], "R10", "histogram bin",
                int'(hist_cnt[b*CW +: CW]), m_hist[b]);
    endtask

    // One cycle: drive, check the group, let the edge update counters, check them.
    task automatic step(input string tag, input bit clr_v);
        int ni, nu, cs, ev, bin;
        drive();
        clr_cnt = clr_v;
        #1;
        ref_group(ni, nu, cs);
        ev = (cs < 0) ? 0 : (1 << cs);
        chk(int'(disp_cnt) == ni, tag, "instructions", int'(disp_cnt), ni);
        chk(int'(disp_uops) == nu, tag, "micro-ops", int'(disp_uops), nu);
        chk(int'(disp_take) == ((1 << ni) - 1), tag, "take mask", int'(disp_take), (1 << ni) - 1);
        chk(int'(stall_cause) == ev, tag, "stall cause", int'(stall_cause), ev);
        if (clr_v) begin
            for (int c = 0; c < NC; c++) m_stall[c] = 0;
            for (int b = 0; b < NB; b++) m_hist[b] = 0;
        end else begin
            if (cs >= 0 && m_stall[cs] < CMX) m_stall[cs]++;
            bin = (nu > MW) ? MW : nu;
            if (m_hist[bin] < CMX) m_hist[bin]++;
        end
        @(posedge clk);
        @(negedge clk);
        cmp_counters();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        set_easy();
        drive();
        for (int c = 0; c < NC; c++) m_stall[c] = 0;
        for (int b = 0; b < NB; b++) m_hist[b] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(stall_cnt == '0, "R12", "stall counters after reset", int'(stall_cnt[CW-1:0]), 0);
        chk(hist_cnt == '0, "R12", "histogram after reset", int'(hist_cnt[CW-1:0]), 0);

        // R8: default, clamp and pass-through widths.
        set_easy(); v_n = 4; cw = 0;  step("R8 default width", 1'b0);
        chk(int'(disp_cnt) == 2, "R8", "default width count", int'(disp_cnt), 2);
        cw = 9;  step("R8 clamped width", 1'b0);
        cw = 3;  step("R8 explicit width", 1'b0);
        // R2: oversized instruction into an empty group, full group is no stall.
        set_easy(); v_n = 2; cw = 1; v_u[0] = 3; step("R2 oversized alone", 1'b0);
        set_easy(); v_n = 4; cw = 2; v_u[1] = 2; step("R2 width stop no stall", 1'b0);
        // R3: reorder buffer limit.
        set_easy(); v_n = 2; rob = 2; v_u[1] = 2; step("R3 rob limit", 1'b0);
        // R5: register limit and unlimited pool.
        set_easy(); v_n = 1; psize = 4; prf = 0; v_r[0] = 1; step("R5 no registers", 1'b0);
        psize = 0; step("R5 unlimited pool", 1'b0);
        // R4: same scheduler collision vs separate schedulers.
        set_easy(); v_n = 2; v_s[1] = 0; sch[0] = 1; step("R4 scheduler full", 1'b0);
        v_s[1] = 1; step("R4 separate schedulers", 1'b0);
        // R6: load and store queue limits.
        set_easy(); v_n = 2; v_ld[0] = 1; v_ld[1] = 1; lq = 1; step("R6 load queue", 1'b0);
        set_easy(); v_n = 1; v_st[0] = 1; sq = 0; step("R6 store queue", 1'b0);
        // R7: solo instruction second, then first.
        set_easy(); v_n = 3; v_solo[1] = 1; step("R7 solo not first", 1'b0);
        set_easy(); v_n = 3; v_solo[0] = 1; step("R7 solo first ends group", 1'b0);
        // R9: several checks fail together, register wins.
        set_easy(); v_n = 2; psize = 2; prf = 1; v_r[1] = 1; v_r[0] = 1; rob = 1;
        v_ld[1] = 1; lq = 0; step("R9 priority", 1'b0);
        // R10: empty queue lands in bin 0.
        set_easy(); step("R10 empty cycle", 1'b0);
        // R11: clear, then saturation of bin 0.
        step("R11 clear", 1'b1);
        chk(hist_cnt == '0 && stall_cnt == '0, "R11", "counters after clear", int'(hist_cnt[CW-1:0]), 0);
        for (int k = 0; k < CMX + 40; k++) step("R11 saturation run", 1'b0);
        chk(int'(hist_cnt[CW-1:0]) == CMX, "R11", "bin 0 saturated", int'(hist_cnt[CW-1:0]), CMX);

        // R1 and all others: constrained random cycles with scarce credits.
        for (int t = 0; t < 1500; t++) begin
            v_n = int'($urandom_range(0, 4));
            for (int i = 0; i < 4; i++) begin
                v_u[i] = int'($urandom_range(1, 3));
                v_r[i] = int'($urandom_range(0, 2));
                v_s[i] = int'($urandom_range(0, 3));
                sch[i] = int'($urandom_range(0, 3));
                v_ld[i] = ($urandom_range(0, 3) == 0);
                v_st[i] = ($urandom_range(0, 3) == 0);
                v_solo[i] = ($urandom_range(0, 7) == 0);
            end
            rob = int'($urandom_range(0, 9));
            prf = int'($urandom_range(0, 6));
            psize = ($urandom_range(0, 3) == 0) ? 0 : 32;
            lq = int'($urandom_range(0, 2));
            sq = int'($urandom_range(0, 2));
            cw = int'($urandom_range(0, 9));
            step("R1 random", ($urandom_range(0, 199) == 0));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule